// File: doc/BRIEF.md
# Wake Join Record Loader and Validator

This block is the responder side of a measured-launch wake-up. After reset it sleeps with INIT masked. A one-cycle wake event ends the sleep. The block first compares its own monitor-control bit with the bit from the initiating processor. If they match, it sets its pin-event masks, asks for a TLB invalidate and waits until outgoing traffic has drained. It then reads a four-word join record, one word per read, through a simple request/response port. The record starts at the base address presented on `join_base_i` when the wake is accepted.

Once the record is loaded, the block checks the table limit and the segment selector. Any failure ends in a terminal shutdown with an error code. A record that passes ends in a terminal done state. There the block drives a snapshot of the architectural state the processor must start with: descriptor-table base and limit, code and data selectors, flat segment descriptors, control, flag, feature and debug registers, and the entry pointer.

The states are SLEEP, INVAL, DRAIN, FETCH, AWAIT, CHECK, DONE and SHUT.

| Transition | Condition |
|---|---|
| SLEEP to INVAL | wake with matching monitor bits |
| SLEEP to SHUT | wake with mismatching monitor bits |
| INVAL to DRAIN | always, after one cycle |
| DRAIN to FETCH | drain done |
| FETCH to AWAIT | always, after one cycle |
| AWAIT to FETCH | response valid while words remain |
| AWAIT to CHECK | response valid for the last word |
| CHECK to DONE | record passes |
| CHECK to SHUT | record fails |
| DONE, SHUT | stay until reset |

Top module: `wake_join_loader`

## Requirements
- R1: After reset the block is in SLEEP. `rd_req_o`, `tlb_inval_o`, `done_o` and `shutdown_o` are 0. `init_mask_o` is 1 and every other mask output is 0.
- R2: A wake with `mon_self_i` different from `mon_peer_i` moves straight to SHUT with `shut_code_o` = 1 (illegal event), and no read is issued.
- R3: An accepted wake sets `smi_mask_o` to `mon_self_i`. It sets `a20m_mask_o`, `nmi_mask_o` and `wake_mask_o` to 1 and clears `init_mask_o` to 0. All of these are visible in the cycle after the wake.
- R4: `tlb_inval_o` is high for exactly the one cycle after an accepted wake. No read is issued before `drain_done_i` has been seen.
- R5: The four reads go to base+0, base+4, base+8 and base+12 in that order. Each `rd_req_o` lasts one cycle, and the next one is issued only after `rd_valid_i` answers the previous one. The words are, in order: table limit, table base, selector, entry pointer.
- R6: If any of bits 31:16 of the limit word is set, the block shuts down with `shut_code_o` = 2 (bad format).
- R7: Let `sel` be the 32-bit selector word. The block shuts down with code 2 if `sel` < 8 or if `sel` + 15 > limit. This is computed without wrap-around, so `sel` = limit − 15 passes.
- R8: The block shuts down with code 2 if selector bit 2 (table indicator) is 1 or bits 1:0 (requested privilege) are nonzero.
- R9: On success, `done_o` = 1, `gdt_limit_o` = limit[15:0], `gdt_base_o` = base word, `eip_o` = entry word, `cs_sel_o` = sel[15:0] and `ds_sel_o` = sel[15:0] + 8. The `ds_sel_o` value also serves the stack and extra segments.
- R10: On success, `seg_base_o` = 0, `seg_limit_o` = FFFFFh, `seg_gran_o` = 1, `seg_dsize_o` = 1, `code_attr_o` = 9Bh and `data_attr_o` = 93h.
- R11: On success, `cr0_o` equals `cr0_i` with bits 31, 30, 29, 18 and 16 cleared and bits 5 and 0 set. The other outputs are fixed: `cr4_o` = 00004000h, `eflags_o` = 00000002h, `efer_o` = 0, `dr7_o` = 00000400h, `dbgctl_o` = 0.
- R12: DONE and SHUT hold until reset, with their flag and code stable, and a later wake is ignored. `done_o` and `shutdown_o` are never both 1. Every snapshot output is 0 when `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wake event pulse |
| mon_self_i | input | 1 | Own monitor-control bit 0 |
| mon_peer_i | input | 1 | Initiator's monitor-control bit 0 |
| join_base_i | input | ADDR_W | Byte address of the join record |
| cr0_i | input | 32 | Current control register 0 |
| tlb_inval_o | output | 1 | TLB invalidate pulse |
| drain_done_i | input | 1 | Outgoing traffic drained |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data |
| smi_mask_o | output | 1 | SMI pin masked |
| a20m_mask_o | output | 1 | A20M pin masked |
| nmi_mask_o | output | 1 | NMI masked |
| init_mask_o | output | 1 | INIT masked |
| wake_mask_o | output | 1 | Further wake events masked |
| done_o | output | 1 | Load succeeded (terminal) |
| shutdown_o | output | 1 | Shutdown raised (terminal) |
| shut_code_o | output | 2 | 0 none, 1 illegal event, 2 bad format |
| gdt_limit_o | output | 16 | Descriptor-table limit |
| gdt_base_o | output | 32 | Descriptor-table base |
| cs_sel_o | output | 16 | Code selector |
| ds_sel_o | output | 16 | Data, stack and extra selector |
| seg_base_o | output | 32 | Segment base |
| seg_limit_o | output | 20 | Segment limit |
| seg_gran_o | output | 1 | Segment granularity |
| seg_dsize_o | output | 1 | Segment default size |
| code_attr_o | output | 8 | Code segment attributes |
| data_attr_o | output | 8 | Data segment attributes |
| cr0_o | output | 32 | Initial control register 0 |
| cr4_o | output | 32 | Initial control register 4 |
| eflags_o | output | 32 | Initial flags |
| efer_o | output | 32 | Initial extended-feature register |
| dr7_o | output | 32 | Initial debug register 7 |
| dbgctl_o | output | 32 | Initial debug-control register |
| eip_o | output | 32 | Entry pointer |

## Verification
The main function is driven with:
- valid records under both monitor-bit values, with zero and nonzero drain and read latencies, to separate the mask setting and the handshake pacing from the record contents;
- failing records, each breaking exactly one rule (high limit bits, selector below 8, selector past the limit, table-indicator bit, privilege bits), so a wrong or missing rule shows as a wrong terminal state;
- a selector exactly at limit − 15, and a limit below 15 that would wrap in a naive subtraction, which separate an off-by-one or wrapping compare from the correct one;
- a monitor-bit mismatch, which must shut down without any read;
- a second wake after each terminal state, which must change nothing.

// File: rtl/wjl_pkg.sv
package wjl_pkg;
    localparam int WORD_W    = 32;
    localparam int SEL_W     = 16;
    localparam int REC_WORDS = 4;
    localparam int SEGLIM_W  = 20;

    typedef enum logic [2:0] {
        ST_SLEEP, ST_INVAL, ST_DRAIN, ST_FETCH,
        ST_AWAIT, ST_CHECK, ST_DONE, ST_SHUT
    } wjl_state_e;

    typedef enum logic [1:0] {
        SD_NONE    = 2'd0,
        SD_ILLEGAL = 2'd1,
        SD_BADFMT  = 2'd2
    } wjl_code_e;

    // fixed initial values loaded on success
    localparam logic [7:0]          CODE_AR    = 8'h9B;
    localparam logic [7:0]          DATA_AR    = 8'h93;
    localparam logic [SEGLIM_W-1:0] FLAT_LIMIT = 20'hFFFFF;
    localparam logic [WORD_W-1:0]   CR4_INIT   = 32'h0000_4000;
    localparam logic [WORD_W-1:0]   FLAGS_INIT = 32'h0000_0002;
    localparam logic [WORD_W-1:0]   DR7_INIT   = 32'h0000_0400;
    // CR0: clear paging(31) cache-disable(30) not-write-through(29) align-mask(18) write-protect(16)
    localparam logic [WORD_W-1:0]   CR0_CLR    = 32'hE005_0000;
    // CR0: set numeric-error(5) and protection-enable(0)
    localparam logic [WORD_W-1:0]   CR0_SET    = 32'h0000_0021;
endpackage

// File: rtl/wjl_validate.sv
module wjl_validate
    import wjl_pkg::*;
(
    input  logic [WORD_W-1:0] limit_w,
    input  logic [WORD_W-1:0] sel_w,
    output logic              bad_o
);
    logic [WORD_W:0] sel_top;
    logic            lim_high, sel_low, sel_over, sel_fmt;

    always_comb begin
        sel_top  = {1'b0, sel_w} + (WORD_W+1)'(15);
        lim_high = |limit_w[WORD_W-1:SEL_W];
        sel_low  = sel_w < WORD_W'(8);
        sel_over = sel_top > {1'b0, limit_w};
        sel_fmt  = sel_w[2] | (|sel_w[1:0]);
        bad_o    = lim_high | sel_low | sel_over | sel_fmt;
    end
endmodule

// File: rtl/wjl_snapshot.sv
module wjl_snapshot
    import wjl_pkg::*;
(
    input  logic                valid_i,
    input  logic [SEL_W-1:0]    limit_i,
    input  logic [WORD_W-1:0]   base_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [WORD_W-1:0]   entry_i,
    input  logic [WORD_W-1:0]   cr0_i,
    output logic [SEL_W-1:0]    gdt_limit_o,
    output logic [WORD_W-1:0]   gdt_base_o,
    output logic [SEL_W-1:0]    cs_sel_o,
    output logic [SEL_W-1:0]    ds_sel_o,
    output logic [WORD_W-1:0]   seg_base_o,
    output logic [SEGLIM_W-1:0] seg_limit_o,
    output logic                seg_gran_o,
    output logic                seg_dsize_o,
    output logic [7:0]          code_attr_o,
    output logic [7:0]          data_attr_o,
    output logic [WORD_W-1:0]   cr0_o,
    output logic [WORD_W-1:0]   cr4_o,
    output logic [WORD_W-1:0]   eflags_o,
    output logic [WORD_W-1:0]   efer_o,
    output logic [WORD_W-1:0]   dr7_o,
    output logic [WORD_W-1:0]   dbgctl_o,
    output logic [WORD_W-1:0]   eip_o
);
    always_comb begin
        gdt_limit_o = '0; gdt_base_o = '0; cs_sel_o = '0; ds_sel_o = '0;
        seg_base_o  = '0; seg_limit_o = '0; seg_gran_o = 1'b0; seg_dsize_o = 1'b0;
        code_attr_o = '0; data_attr_o = '0; cr0_o = '0; cr4_o = '0;
        eflags_o    = '0; efer_o = '0; dr7_o = '0; dbgctl_o = '0; eip_o = '0;
        if (valid_i) begin
            gdt_limit_o = limit_i;
            gdt_base_o  = base_i;
            cs_sel_o    = sel_i;
            ds_sel_o    = sel_i + SEL_W'(8);
            seg_limit_o = FLAT_LIMIT;
            seg_gran_o  = 1'b1;
            seg_dsize_o = 1'b1;
            code_attr_o = CODE_AR;
            data_attr_o = DATA_AR;
            cr0_o       = (cr0_i & ~CR0_CLR) | CR0_SET;
            cr4_o       = CR4_INIT;
            eflags_o    = FLAGS_INIT;
            dr7_o       = DR7_INIT;
            eip_o       = entry_i;
        end
    end
endmodule

// File: rtl/wake_join_loader.sv
module wake_join_loader
    import wjl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wake_i,
    input  logic                mon_self_i,
    input  logic                mon_peer_i,
    input  logic [ADDR_W-1:0]   join_base_i,
    input  logic [WORD_W-1:0]   cr0_i,
    output logic                tlb_inval_o,
    input  logic                drain_done_i,
    output logic                rd_req_o,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic                rd_valid_i,
    input  logic [WORD_W-1:0]   rd_data_i,
    output logic                smi_mask_o,
    output logic                a20m_mask_o,
    output logic                nmi_mask_o,
    output logic                init_mask_o,
    output logic                wake_mask_o,
    output logic                done_o,
    output logic                shutdown_o,
    output logic [1:0]          shut_code_o,
    output logic [SEL_W-1:0]    gdt_limit_o,
    output logic [WORD_W-1:0]   gdt_base_o,
    output logic [SEL_W-1:0]    cs_sel_o,
    output logic [SEL_W-1:0]    ds_sel_o,
    output logic [WORD_W-1:0]   seg_base_o,
    output logic [SEGLIM_W-1:0] seg_limit_o,
    output logic                seg_gran_o,
    output logic                seg_dsize_o,
    output logic [7:0]          code_attr_o,
    output logic [7:0]          data_attr_o,
    output logic [WORD_W-1:0]   cr0_o,
    output logic [WORD_W-1:0]   cr4_o,
    output logic [WORD_W-1:0]   eflags_o,
    output logic [WORD_W-1:0]   efer_o,
    output logic [WORD_W-1:0]   dr7_o,
    output logic [WORD_W-1:0]   dbgctl_o,
    output logic [WORD_W-1:0]   eip_o
);
    localparam int               IDX_W    = $clog2(REC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);
    // record word positions
    localparam int W_LIMIT = 0;
    localparam int W_BASE  = 1;
    localparam int W_SEL   = 2;
    localparam int W_ENTRY = 3;

    wjl_state_e          state_q, state_d;
    wjl_code_e           code_q;
    logic [IDX_W-1:0]    idx_q;
    logic [ADDR_W-1:0]   base_q;
    logic [WORD_W-1:0]   rec_q [REC_WORDS];
    logic                smi_q, a20m_q, nmi_q, init_q, wmask_q;
    logic                mon_ok, rec_bad;

    assign mon_ok = (mon_self_i == mon_peer_i);

    wjl_validate u_validate (
        .limit_w (rec_q[W_LIMIT]),
        .sel_w   (rec_q[W_SEL]),
        .bad_o   (rec_bad)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: if (wake_i)       state_d = mon_ok ? ST_INVAL : ST_SHUT;
            ST_INVAL:                   state_d = ST_DRAIN;
            ST_DRAIN: if (drain_done_i) state_d = ST_FETCH;
            ST_FETCH:                   state_d = ST_AWAIT;
            ST_AWAIT: if (rd_valid_i)   state_d = (idx_q == LAST_IDX) ? ST_CHECK : ST_FETCH;
            ST_CHECK:                   state_d = rec_bad ? ST_SHUT : ST_DONE;
            ST_DONE:                    state_d = ST_DONE;
            ST_SHUT:                    state_d = ST_SHUT;
            default:                    state_d = ST_SHUT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            base_q  <= '0;
            code_q  <= SD_NONE;
            smi_q   <= 1'b0;
            a20m_q  <= 1'b0;
            nmi_q   <= 1'b0;
            init_q  <= 1'b1;
            wmask_q <= 1'b0;
            for (int i = 0; i < REC_WORDS; i++) rec_q[i] <= '0;
        end else begin
            if (state_q == ST_SLEEP && wake_i) begin
                base_q <= join_base_i;
                if (mon_ok) begin
                    smi_q   <= mon_self_i;
                    a20m_q  <= 1'b1;
                    nmi_q   <= 1'b1;
                    init_q  <= 1'b0;
                    wmask_q <= 1'b1;
                end else begin
                    code_q  <= SD_ILLEGAL;
                end
            end
            if (state_q == ST_AWAIT && rd_valid_i) begin
                rec_q[idx_q] <= rd_data_i;
                idx_q        <= idx_q + 1'b1;
            end
            if (state_q == ST_CHECK && rec_bad) code_q <= SD_BADFMT;
        end
    end

    // outputs
    always_comb begin
        tlb_inval_o = (state_q == ST_INVAL);
        rd_req_o    = (state_q == ST_FETCH);
        rd_addr_o   = base_q + ADDR_W'({idx_q, 2'b00});
        done_o      = (state_q == ST_DONE);
        shutdown_o  = (state_q == ST_SHUT);
        shut_code_o = code_q;
        smi_mask_o  = smi_q;
        a20m_mask_o = a20m_q;
        nmi_mask_o  = nmi_q;
        init_mask_o = init_q;
        wake_mask_o = wmask_q;
    end

    wjl_snapshot u_snapshot (
        .valid_i     (state_q == ST_DONE),
        .limit_i     (rec_q[W_LIMIT][SEL_W-1:0]),
        .base_i      (rec_q[W_BASE]),
        .sel_i       (rec_q[W_SEL][SEL_W-1:0]),
        .entry_i     (rec_q[W_ENTRY]),
        .cr0_i       (cr0_i),
        .gdt_limit_o (gdt_limit_o),
        .gdt_base_o  (gdt_base_o),
        .cs_sel_o    (cs_sel_o),
        .ds_sel_o    (ds_sel_o),
        .seg_base_o  (seg_base_o),
        .seg_limit_o (seg_limit_o),
        .seg_gran_o  (seg_gran_o),
        .seg_dsize_o (seg_dsize_o),
        .code_attr_o (code_attr_o),
        .data_attr_o (data_attr_o),
        .cr0_o       (cr0_o),
        .cr4_o       (cr4_o),
        .eflags_o    (eflags_o),
        .efer_o      (efer_o),
        .dr7_o       (dr7_o),
        .dbgctl_o    (dbgctl_o),
        .eip_o       (eip_o)
    );
endmodule

// File: rtl/wake_join_loader_chk.sv
module wake_join_loader_chk
    import wjl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wake_i,
    input logic              tlb_inval_o,
    input logic              rd_req_o,
    input logic              done_o,
    input logic              shutdown_o,
    input logic [1:0]        shut_code_o,
    input logic [SEL_W-1:0]  gdt_limit_o,
    input logic [SEL_W-1:0]  cs_sel_o,
    input logic [SEL_W-1:0]  ds_sel_o,
    input logic              a20m_mask_o,
    input logic              nmi_mask_o,
    input logic              init_mask_o,
    input logic              wake_mask_o,
    input logic [WORD_W-1:0] eip_o
);
    p_inval_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval_o |=> !tlb_inval_o);

    p_inval_follows_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval_o |-> $past(wake_i));

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    p_shut_has_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> (shut_code_o != 2'd0));

    p_done_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (a20m_mask_o && nmi_mask_o && !init_mask_o && wake_mask_o));

    p_done_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_sel_o[2:0] == 3'd0));

    p_done_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_sel_o >= SEL_W'(8)) &&
                   ({1'b0, cs_sel_o} + (SEL_W+1)'(15) <= {1'b0, gdt_limit_o}));

    p_data_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ds_sel_o == cs_sel_o + SEL_W'(8)));

    p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(cs_sel_o) && $stable(eip_o)));

    p_shut_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> (shutdown_o && $stable(shut_code_o)));

    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && shutdown_o));
endmodule

bind wake_join_loader wake_join_loader_chk u_chk (.*);

// File: tb/tb_wake_join_loader.sv
module tb_wake_join_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wake_i = 1'b0, mon_self_i = 1'b0, mon_peer_i = 1'b0;
    logic [31:0] join_base_i = '0, cr0_i = '0, rd_data_i = '0;
    logic        drain_done_i = 1'b0, rd_valid_i = 1'b0;
    logic        tlb_inval_o, rd_req_o;
    logic [31:0] rd_addr_o;
    logic        smi_mask_o, a20m_mask_o, nmi_mask_o, init_mask_o, wake_mask_o;
    logic        done_o, shutdown_o;
    logic [1:0]  shut_code_o;
    logic [15:0] gdt_limit_o, cs_sel_o, ds_sel_o;
    logic [31:0] gdt_base_o, seg_base_o;
    logic [19:0] seg_limit_o;
    logic        seg_gran_o, seg_dsize_o;
    logic [7:0]  code_attr_o, data_attr_o;
    logic [31:0] cr0_o, cr4_o, eflags_o, efer_o, dr7_o, dbgctl_o, eip_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wake_join_loader dut (.*);

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wake_i = 0; drain_done_i = 0; rd_valid_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // full wake/load sequence with self-computed expectations
    task automatic run_case(input string name, input logic [31:0] lim, input logic [31:0] gbase,
                            input logic [31:0] sel, input logic [31:0] entry,
                            input logic ms, input logic mp, input int drain_wait, input int lat,
                            input logic [31:0] jbase, input logic [31:0] cr0v);
        logic [31:0] w [4];
        logic        exp_bad, early_req, extra_req;
        logic [15:0] keep_cs;
        logic [31:0] keep_eip;
        logic [1:0]  keep_code;
        int          n;
        w[0] = lim; w[1] = gbase; w[2] = sel; w[3] = entry;
        exp_bad = (lim[31:16] != 0) || (sel < 8) || ({1'b0, sel} + 33'd15 > {1'b0, lim}) ||
                  sel[2] || (sel[1:0] != 0);
        do_reset();
        chk({name, " R1 idle flags"}, {rd_req_o, tlb_inval_o, done_o, shutdown_o}, 4'b0000);
        chk({name, " R1 masks"}, {smi_mask_o, a20m_mask_o, nmi_mask_o, init_mask_o, wake_mask_o}, 5'b00010);
        mon_self_i = ms; mon_peer_i = mp; join_base_i = jbase; cr0_i = cr0v; wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
        if (ms != mp) begin
            chk({name, " R2 shutdown"}, {shutdown_o, done_o}, 2'b10);
            chk({name, " R2 code"}, shut_code_o, 2'd1);
            early_req = 0;
            repeat (3) begin @(negedge clk); if (rd_req_o || tlb_inval_o) early_req = 1; end
            chk({name, " R2 no read"}, early_req, 1'b0);
        end else begin
            chk({name, " R4 inval pulse"}, tlb_inval_o, 1'b1);
            chk({name, " R3 masks"}, {smi_mask_o, a20m_mask_o, nmi_mask_o, init_mask_o, wake_mask_o},
                {ms, 4'b1101});
            @(negedge clk);
            chk({name, " R4 inval one cycle"}, tlb_inval_o, 1'b0);
            early_req = rd_req_o;
            for (int k = 0; k < drain_wait; k++) begin @(negedge clk); if (rd_req_o) early_req = 1; end
            chk({name, " R4 wait for drain"}, early_req, 1'b0);
            drain_done_i = 1'b1;
            @(negedge clk);
            drain_done_i = 1'b0;
            for (int i = 0; i < 4; i++) begin
                n = 0;
                while (!rd_req_o && n < 20) begin @(negedge clk); n++; end
                chk($sformatf("%s R5 addr word %0d", name, i), rd_addr_o, jbase + 32'(4 * i));
                @(negedge clk);
                extra_req = rd_req_o;
                for (int k = 0; k < lat; k++) begin @(negedge clk); if (rd_req_o) extra_req = 1; end
                chk($sformatf("%s R5 single outstanding %0d", name, i), extra_req, 1'b0);
                rd_valid_i = 1'b1; rd_data_i = w[i];
                @(negedge clk);
                rd_valid_i = 1'b0; rd_data_i = '0;
            end
            n = 0;
            while (!done_o && !shutdown_o && n < 10) begin @(negedge clk); n++; end
            if (exp_bad) begin
                chk({name, " R6 R7 R8 shutdown"}, {shutdown_o, done_o}, 2'b10);
                chk({name, " R6 R7 R8 code"}, shut_code_o, 2'd2);
                chk({name, " R12 snapshot zero"}, {cs_sel_o, eip_o, cr4_o}, '0);
            end else begin
                chk({name, " R9 done"}, {done_o, shutdown_o}, 2'b10);
                chk({name, " R9 table"}, {gdt_limit_o, gdt_base_o}, {lim[15:0], gbase});
                chk({name, " R9 selectors"}, {cs_sel_o, ds_sel_o}, {sel[15:0], sel[15:0] + 16'd8});
                chk({name, " R9 entry"}, eip_o, entry);
                chk({name, " R10 segments"}, {seg_base_o, seg_limit_o, seg_gran_o, seg_dsize_o},
                    {32'h0, 20'hFFFFF, 2'b11});
                chk({name, " R10 attrs"}, {code_attr_o, data_attr_o}, 16'h9B93);
                chk({name, " R11 cr0"}, cr0_o, (cr0v & ~32'hE005_0000) | 32'h21);
                chk({name, " R11 cr4 flags"}, {cr4_o, eflags_o}, {32'h4000, 32'h2});
                chk({name, " R11 efer dr7"}, {efer_o, dr7_o}, {32'h0, 32'h400});
                chk({name, " R11 dbgctl"}, dbgctl_o, 32'h0);
                chk({name, " R3 masks kept"}, {smi_mask_o, wake_mask_o}, {ms, 1'b1});
            end
        end
        // R12: terminal state ignores another wake
        keep_cs = cs_sel_o; keep_eip = eip_o; keep_code = shut_code_o;
        n = {done_o, shutdown_o};
        wake_i = 1'b1; mon_self_i = ~ms;
        @(negedge clk);
        wake_i = 1'b0;
        repeat (3) @(negedge clk);
        chk({name, " R12 terminal hold"}, {done_o, shutdown_o, shut_code_o, cs_sel_o, eip_o},
            {n[1:0], keep_code, keep_cs, keep_eip});
        chk({name, " R12 no read after end"}, {rd_req_o, tlb_inval_o}, 2'b00);
    endtask

    task automatic t_good_mon0();   run_case("good0", 32'h00FF, 32'h0010_0000, 32'h10, 32'h0040_1000, 0, 0, 0, 0, 32'h1000, 32'hFFFF_FFFF); endtask
    task automatic t_good_mon1();   run_case("good1", 32'h0100, 32'hABCD_0000, 32'h28, 32'h1234_5678, 1, 1, 3, 2, 32'h8000_0F00, 32'h0); endtask
    task automatic t_illegal();     run_case("illegal", 32'h00FF, 32'h0, 32'h10, 32'h0, 1, 0, 0, 0, 32'h2000, 32'h0); endtask
    task automatic t_limit_high();  run_case("limhigh", 32'h0001_00FF, 32'h0, 32'h10, 32'h0, 0, 0, 1, 1, 32'h3000, 32'h0); endtask
    task automatic t_sel_low();     run_case("sellow", 32'h00FF, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 32'h3000, 32'h0); endtask
    task automatic t_sel_over();    run_case("selover", 32'h0040, 32'h0, 32'h38, 32'h0, 0, 0, 0, 1, 32'h3000, 32'h0); endtask
    task automatic t_sel_edge();    run_case("seledge", 32'h0047, 32'h5, 32'h38, 32'h77, 0, 0, 0, 0, 32'h4000, 32'h8000_0000); endtask
    task automatic t_small_limit(); run_case("smalllim", 32'h0005, 32'h0, 32'h08, 32'h0, 0, 0, 0, 0, 32'h4000, 32'h0); endtask
    task automatic t_ti();          run_case("ti", 32'h00FF, 32'h0, 32'h14, 32'h0, 0, 0, 0, 0, 32'h5000, 32'h0); endtask
    task automatic t_rpl();         run_case("rpl", 32'h00FF, 32'h0, 32'h13, 32'h0, 1, 1, 0, 0, 32'h5000, 32'h0); endtask

    initial begin
        t_good_mon0();
        t_good_mon1();
        t_illegal();
        t_limit_high();
        t_sel_low();
        t_sel_over();
        t_sel_edge();
        t_small_limit();
        t_ti();
        t_rpl();
        summary();
    end
endmodule